// File: doc/BRIEF.md
# Four-State Ownership Coherence Controller

This block tracks the coherence state of one line of a large local memory that acts as a cache for a shared-bus multiprocessor. The protocol is write-invalidate, and every line has a single owner. The block has no dirty bit. Ownership alone decides which node answers a bus request with data, so only a line in one of the two owner states (shared owner or exclusive) ever drives the supply flag.

Each cycle the controller may receive three kinds of input:

- a local processor event: read, write, or a read that also needs a relocation;
- a snooped bus event: read, write, invalidate, ownership transfer, no-other-copies install, or read-with-ownership;
- a fill that completes the single bus request the controller may have outstanding.

From these it decides which bus transaction to issue, whether to supply data, and the line state after the next clock edge. The snoop is applied first, and the local event is judged against the state the snoop leaves behind. A fill takes effect over both. Tag lookup, the data array and arbitration are handled outside the block.

Top module: `own_coh_ctrl`

## Requirements
- R1: After reset the line state is invalid (code 00), no request is issued, supply is low and busy is low.
- R2: A local read (loc_op 00) on an invalid line issues a bus read (req_op 00) and sets busy. The fill that follows installs the line as shared non-owner (01), or as exclusive (11) when fill_page is high.
- R3: A snooped read (snp_op 0) on an exclusive line raises supply and moves the line to shared owner (10). On a shared-owner line it raises supply and keeps the state. On a shared non-owner line it raises no supply.
- R4: A local write (loc_op 01) on a shared non-owner or shared-owner line issues a bus invalidate (req_op 10) without setting busy, and the line becomes exclusive at the next edge. A write on an exclusive line issues nothing.
- R5: A local write on an invalid line issues a bus write (req_op 01) and sets busy, and the fill installs the line as exclusive. A snooped write (snp_op 1) invalidates any valid copy and raises supply when the line was in an owner state.
- R6: A snooped invalidate (snp_op 2) moves any line to invalid without supplying data.
- R7: A snooped ownership transfer (snp_op 3) moves a shared non-owner line to shared owner without supply, and leaves every other state unchanged.
- R8: A snooped no-other-copies install (snp_op 4) leaves the line exclusive.
- R9: A local read with relocation (loc_op 10) on an invalid line issues a read-with-ownership (req_op 11), and its fill installs the line as shared owner. A snooped read-with-ownership (snp_op 5) on an owner line raises supply and drops the line to shared non-owner.
- R10: line_hit is high exactly when the state is not invalid, and supply is only ever high while the line is in an owner state.
- R11: When a snoop and a local event fall in the same cycle, the local event is decided on the state the snoop leaves behind.
- R12: While busy, local events issue nothing. A fill with no outstanding request, loc_op 11 and snp_op 6 or 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loc_valid | input | 1 | Local processor event present |
| loc_op | input | 2 | Local event: 00 read, 01 write, 10 read with relocation, 11 none |
| snp_valid | input | 1 | Snooped bus event present |
| snp_op | input | 3 | Snoop: 0 read, 1 write, 2 invalidate, 3 ownership transfer, 4 no-other-copies install, 5 read with ownership |
| fill_valid | input | 1 | Data for the outstanding request has arrived |
| fill_page | input | 1 | The fill comes from a page fault |
| line_state | output | 2 | Current state: 00 invalid, 01 shared non-owner, 10 shared owner, 11 exclusive |
| line_hit | output | 1 | Line holds valid data |
| busy | output | 1 | A bus request is outstanding |
| req_valid | output | 1 | Bus request issued this cycle |
| req_op | output | 2 | Request: 00 read, 01 write, 10 invalidate, 11 read with ownership |
| supply | output | 1 | This node supplies data for the snooped request |

## Verification
A snoop and a local event can arrive in the same cycle. Two pairings are driven to exercise this. In the first, a snooped invalidate lands together with a write on a shared-owner line. The write must then come out as a bus write with busy set, not as an upgrade invalidate. In the second, a snooped read lands together with a write on an exclusive line. The line must supply data, pass through shared owner, and leave with an upgrade invalidate that ends exclusive. The scoreboard predicts both outcomes from the snoop-first ordering and compares the request, the supply flag and the registered state.

// File: rtl/coh_pkg.sv
package coh_pkg;
   localparam int ST_W  = 2;
   localparam int LOC_W = 2;
   localparam int SNP_W = 3;
   localparam int REQ_W = 2;

   typedef enum logic [ST_W-1:0] {
      ST_INV = 2'b00,
      ST_SHN = 2'b01,
      ST_SHO = 2'b10,
      ST_EXL = 2'b11
   } line_st_t;

   typedef enum logic [LOC_W-1:0] {
      LOC_RD    = 2'b00,
      LOC_WR    = 2'b01,
      LOC_RDREL = 2'b10,
      LOC_NONE  = 2'b11
   } loc_op_t;

   typedef enum logic [SNP_W-1:0] {
      SN_RD   = 3'd0,
      SN_WR   = 3'd1,
      SN_INV  = 3'd2,
      SN_XFER = 3'd3,
      SN_NNOC = 3'd4,
      SN_RDO  = 3'd5,
      SN_NOP6 = 3'd6,
      SN_NOP7 = 3'd7
   } snp_op_t;

   typedef enum logic [REQ_W-1:0] {
      RQ_RD  = 2'b00,
      RQ_WR  = 2'b01,
      RQ_INV = 2'b10,
      RQ_RDO = 2'b11
   } req_op_t;

   typedef enum logic [1:0] {
      PD_NONE = 2'b00,
      PD_RD   = 2'b01,
      PD_WR   = 2'b10,
      PD_RDO  = 2'b11
   } pend_t;

   function automatic logic is_owner(line_st_t s);
      return (s == ST_SHO) || (s == ST_EXL);
   endfunction
endpackage

// File: rtl/coh_snoop_step.sv
module coh_snoop_step
   import coh_pkg::*;
(
   input  line_st_t cur_st,
   input  logic     snp_valid,
   input  snp_op_t  snp_op,
   output line_st_t mid_st,
   output logic     sup_now
);
   always_comb begin
      mid_st  = cur_st;
      sup_now = 1'b0;
      if (snp_valid) begin
         case (snp_op)
            SN_RD: begin
               sup_now = is_owner(cur_st);
               if (cur_st == ST_EXL) mid_st = ST_SHO;
            end
            SN_WR: begin
               sup_now = is_owner(cur_st);
               mid_st  = ST_INV;
            end
            SN_INV:  mid_st = ST_INV;
            SN_XFER: if (cur_st == ST_SHN) mid_st = ST_SHO;
            SN_NNOC: mid_st = ST_EXL;
            SN_RDO: begin
               if (is_owner(cur_st)) begin
                  sup_now = 1'b1;
                  mid_st  = ST_SHN;
               end
            end
            default: mid_st = cur_st;
         endcase
      end
   end
endmodule

// File: rtl/coh_local_step.sv
module coh_local_step
   import coh_pkg::*;
(
   input  line_st_t mid_st,
   input  logic     loc_valid,
   input  loc_op_t  loc_op,
   input  logic     busy,
   output line_st_t new_st,
   output logic     rq_valid,
   output req_op_t  rq_op,
   output pend_t    start_pend
);
   always_comb begin
      new_st     = mid_st;
      rq_valid   = 1'b0;
      rq_op      = RQ_RD;
      start_pend = PD_NONE;
      if (loc_valid && !busy) begin
         case (loc_op)
            LOC_RD: begin
               if (mid_st == ST_INV) begin
                  rq_valid   = 1'b1;
                  rq_op      = RQ_RD;
                  start_pend = PD_RD;
               end
            end
            LOC_WR: begin
               if (mid_st == ST_SHN || mid_st == ST_SHO) begin
                  rq_valid = 1'b1;
                  rq_op    = RQ_INV;
                  new_st   = ST_EXL;
               end else if (mid_st == ST_INV) begin
                  rq_valid   = 1'b1;
                  rq_op      = RQ_WR;
                  start_pend = PD_WR;
               end
            end
            LOC_RDREL: begin
               if (mid_st == ST_INV) begin
                  rq_valid   = 1'b1;
                  rq_op      = RQ_RDO;
                  start_pend = PD_RDO;
               end
            end
            default: rq_valid = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/coh_fill_step.sv
module coh_fill_step
   import coh_pkg::*;
#(
   parameter bit PAGE_FILL_EXCL = 1'b1
) (
   input  pend_t    pend,
   input  logic     fill_valid,
   input  logic     fill_page,
   output logic     fill_take,
   output line_st_t fill_st
);
   logic page_excl;

   generate
      if (PAGE_FILL_EXCL) begin : g_page_excl
         assign page_excl = fill_page;
      end else begin : g_page_shared
         assign page_excl = 1'b0;
      end
   endgenerate

   assign fill_take = fill_valid && (pend != PD_NONE);

   always_comb begin
      case (pend)
         PD_RD:   fill_st = page_excl ? ST_EXL : ST_SHN;
         PD_WR:   fill_st = ST_EXL;
         PD_RDO:  fill_st = ST_SHO;
         default: fill_st = ST_INV;
      endcase
   end
endmodule

// File: rtl/own_coh_ctrl.sv
module own_coh_ctrl
   import coh_pkg::*;
#(
   parameter bit REG_SUPPLY     = 1'b0,
   parameter bit PAGE_FILL_EXCL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             loc_valid,
   input  logic [LOC_W-1:0] loc_op,
   input  logic             snp_valid,
   input  logic [SNP_W-1:0] snp_op,
   input  logic             fill_valid,
   input  logic             fill_page,
   output logic [ST_W-1:0]  line_state,
   output logic             line_hit,
   output logic             busy,
   output logic             req_valid,
   output logic [REQ_W-1:0] req_op,
   output logic             supply
);
   if (ST_W != 2)  $error("state field must be two bits");
   if (SNP_W < 3)  $error("snoop op field too narrow");
   if (LOC_W < 2)  $error("local op field too narrow");

   line_st_t st_q, st_d, mid_st, loc_st, fill_st;
   pend_t    pend_q, pend_d, start_pend;
   logic     sup_now, fill_take, rq_valid;
   req_op_t  rq_op;

   coh_snoop_step u_snoop (
      .cur_st    (st_q),
      .snp_valid (snp_valid),
      .snp_op    (snp_op_t'(snp_op)),
      .mid_st    (mid_st),
      .sup_now   (sup_now)
   );

   coh_local_step u_local (
      .mid_st     (mid_st),
      .loc_valid  (loc_valid),
      .loc_op     (loc_op_t'(loc_op)),
      .busy       (busy),
      .new_st     (loc_st),
      .rq_valid   (rq_valid),
      .rq_op      (rq_op),
      .start_pend (start_pend)
   );

   coh_fill_step #(.PAGE_FILL_EXCL(PAGE_FILL_EXCL)) u_fill (
      .pend       (pend_q),
      .fill_valid (fill_valid),
      .fill_page  (fill_page),
      .fill_take  (fill_take),
      .fill_st    (fill_st)
   );

   assign busy = (pend_q != PD_NONE);

   always_comb begin
      if (fill_take) begin
         st_d   = fill_st;
         pend_d = PD_NONE;
      end else begin
         st_d   = loc_st;
         pend_d = (start_pend != PD_NONE) ? start_pend : pend_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_INV;
         pend_q <= PD_NONE;
      end else begin
         st_q   <= st_d;
         pend_q <= pend_d;
      end
   end

   generate
      if (REG_SUPPLY) begin : g_sup_reg
         logic sup_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sup_q <= 1'b0;
            else        sup_q <= sup_now;
         end
         assign supply = sup_q;
      end else begin : g_sup_comb
         assign supply = sup_now;
      end
   endgenerate

   assign line_state = st_q;
   assign line_hit   = (st_q != ST_INV);
   assign req_valid  = rq_valid;
   assign req_op     = rq_op;
endmodule

// File: rtl/own_coh_ctrl_chk.sv
module own_coh_ctrl_chk
   import coh_pkg::*;
#(
   parameter bit REG_SUPPLY = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             loc_valid,
   input logic [SNP_W-1:0] snp_op,
   input logic             snp_valid,
   input logic [ST_W-1:0]  line_state,
   input logic             busy,
   input logic             req_valid,
   input logic [REQ_W-1:0] req_op,
   input logic             supply
);
   // R12: no request may leave while one is outstanding
   a_r12_no_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !req_valid);

   // R4: an upgrade invalidate leaves the line exclusive and idle
   a_r4_upgrade_excl: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'b10) |=> (line_state == 2'b11 && !busy));

   // R2: data requests set busy for the next cycle
   a_r2_miss_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op != 2'b10) |=> busy);

   // R6: a snooped invalidate leaves the line invalid
   a_r6_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_op == 3'd2 && !busy) |=> line_state == 2'b00);

   // R7: ownership transfer promotes a non-owner copy
   a_r7_xfer_promote: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_op == 3'd3 && line_state == 2'b01 && !busy && !loc_valid)
      |=> line_state == 2'b10);

   generate
      if (!REG_SUPPLY) begin : g_comb_sup
         // R10: supply only from an owner state
         a_r10_supply_owner: assert property (@(posedge clk) disable iff (!rst_n)
            supply |-> line_state[1]);
         // R3: a snooped read on an exclusive line must supply
         a_r3_excl_supplies: assert property (@(posedge clk) disable iff (!rst_n)
            (snp_valid && snp_op == 3'd0 && line_state == 2'b11) |-> supply);
      end
   endgenerate
endmodule

bind own_coh_ctrl own_coh_ctrl_chk #(.REG_SUPPLY(REG_SUPPLY)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .loc_valid  (loc_valid),
   .snp_op     (snp_op),
   .snp_valid  (snp_valid),
   .line_state (line_state),
   .busy       (busy),
   .req_valid  (req_valid),
   .req_op     (req_op),
   .supply     (supply)
);

// File: tb/own_coh_ctrl_tb.sv
`timescale 1ns/1ps
module own_coh_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       loc_valid = 1'b0;
   logic [1:0] loc_op = 2'b11;
   logic       snp_valid = 1'b0;
   logic [2:0] snp_op = 3'd6;
   logic       fill_valid = 1'b0;
   logic       fill_page = 1'b0;
   logic [1:0] line_state;
   logic       line_hit, busy, req_valid, supply;
   logic [1:0] req_op;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   own_coh_ctrl u_dut (
      .clk(clk), .rst_n(rst_n),
      .loc_valid(loc_valid), .loc_op(loc_op),
      .snp_valid(snp_valid), .snp_op(snp_op),
      .fill_valid(fill_valid), .fill_page(fill_page),
      .line_state(line_state), .line_hit(line_hit), .busy(busy),
      .req_valid(req_valid), .req_op(req_op), .supply(supply)
   );

   typedef struct {
      logic       rv;
      logic [1:0] rq;
      logic       sup;
      logic       hit;
      logic       bsy;
      logic [1:0] st;
      string      tag;
   } exp_t;

   exp_t q[$];

   // bench reference state, derived from the requirements
   logic [1:0] m_st = 2'b00;
   logic [1:0] m_pend = 2'b00;   // 0 none, 1 read, 2 write, 3 read-own

   task automatic check(string tag, string what, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   task automatic step(input logic lv, input logic [1:0] lo,
                       input logic sv, input logic [2:0] so,
                       input logic fv, input logic fp, input string tag);
      exp_t e;
      logic [1:0] mid, nxt;
      @(negedge clk);
      e.tag = tag;
      e.hit = (m_st != 2'b00);
      e.bsy = (m_pend != 2'b00);
      e.sup = 1'b0;
      e.rv  = 1'b0;
      e.rq  = 2'b00;
      mid = m_st;
      if (sv) begin
         case (so)
            3'd0: begin e.sup = m_st[1]; if (m_st == 2'b11) mid = 2'b10; end
            3'd1: begin e.sup = m_st[1]; mid = 2'b00; end
            3'd2: mid = 2'b00;
            3'd3: if (m_st == 2'b01) mid = 2'b10;
            3'd4: mid = 2'b11;
            3'd5: if (m_st[1]) begin e.sup = 1'b1; mid = 2'b01; end
            default: ;
         endcase
      end
      nxt = mid;
      if (lv && m_pend == 2'b00) begin
         case (lo)
            2'b00: if (mid == 2'b00) begin e.rv = 1; e.rq = 2'b00; m_pend = 2'd1; end
            2'b01: begin
               if (mid == 2'b01 || mid == 2'b10) begin e.rv = 1; e.rq = 2'b10; nxt = 2'b11; end
               else if (mid == 2'b00) begin e.rv = 1; e.rq = 2'b01; m_pend = 2'd2; end
            end
            2'b10: if (mid == 2'b00) begin e.rv = 1; e.rq = 2'b11; m_pend = 2'd3; end
            default: ;
         endcase
      end else if (fv && m_pend != 2'b00) begin
         case (m_pend)
            2'd1: nxt = fp ? 2'b11 : 2'b01;
            2'd2: nxt = 2'b11;
            default: nxt = 2'b10;
         endcase
         m_pend = 2'd0;
      end
      m_st = nxt;
      e.st = nxt;
      q.push_back(e);
      loc_valid = lv; loc_op = lo; snp_valid = sv; snp_op = so;
      fill_valid = fv; fill_page = fp;
   endtask

   task automatic idle();
      @(negedge clk);
      loc_valid = 0; loc_op = 2'b11; snp_valid = 0; snp_op = 3'd6;
      fill_valid = 0; fill_page = 0;
   endtask

   // monitor: combinational outputs before the edge, state after it
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         #1;
         if (q.size() > 0) begin
            e = q.pop_front();
            check(e.tag, "req_valid", int'(req_valid), int'(e.rv));
            if (e.rv) check(e.tag, "req_op", int'(req_op), int'(e.rq));
            check(e.tag, "supply", int'(supply), int'(e.sup));
            check({e.tag, " R10"}, "line_hit", int'(line_hit), int'(e.hit));
            check(e.tag, "busy", int'(busy), int'(e.bsy));
            @(posedge clk);
            #1;
            check(e.tag, "line_state", int'(line_state), int'(e.st));
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1", "line_state", int'(line_state), 0);
      check("R1", "req_valid", int'(req_valid), 0);
      check("R1", "supply", int'(supply), 0);
      check("R1", "busy", int'(busy), 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle();

      // R2 read miss then ordinary fill
      step(1, 2'b00, 0, 3'd6, 0, 0, "R2 read miss");
      step(0, 2'b11, 0, 3'd6, 1, 0, "R2 fill shared");
      // R3 snooped read on non-owner
      step(0, 2'b11, 1, 3'd0, 0, 0, "R3 read on SHN");
      // R4 upgrade from non-owner, then write on exclusive
      step(1, 2'b01, 0, 3'd6, 0, 0, "R4 write hit SHN");
      step(1, 2'b01, 0, 3'd6, 0, 0, "R4 write hit EXL");
      // R3 snooped reads on owner states
      step(0, 2'b11, 1, 3'd0, 0, 0, "R3 read on EXL");
      step(0, 2'b11, 1, 3'd0, 0, 0, "R3 read on SHO");
      // R7 transfer has no effect on owner, R6 invalidate
      step(0, 2'b11, 1, 3'd3, 0, 0, "R7 xfer on SHO");
      step(0, 2'b11, 1, 3'd2, 0, 0, "R6 invalidate");
      // R5 write miss with R12 local op while busy
      step(1, 2'b01, 0, 3'd6, 0, 0, "R5 write miss");
      step(1, 2'b00, 0, 3'd6, 0, 0, "R12 read while busy");
      step(0, 2'b11, 0, 3'd6, 1, 0, "R5 fill excl");
      step(0, 2'b11, 1, 3'd1, 0, 0, "R5 snoop write on EXL");
      // R12 stray fill, unused codes
      step(0, 2'b11, 0, 3'd6, 1, 1, "R12 stray fill");
      step(1, 2'b11, 1, 3'd7, 0, 0, "R12 unused codes");
      // R9 read with relocation
      step(1, 2'b10, 0, 3'd6, 0, 0, "R9 read reloc miss");
      step(0, 2'b11, 0, 3'd6, 1, 0, "R9 fill owner");
      step(0, 2'b11, 1, 3'd5, 0, 0, "R9 read-own on SHO");
      // R7 transfer promotes non-owner
      step(0, 2'b11, 1, 3'd3, 0, 0, "R7 xfer on SHN");
      // R11 invalidate and write in the same cycle
      step(1, 2'b01, 1, 3'd2, 0, 0, "R11 inv with write");
      step(0, 2'b11, 0, 3'd6, 1, 0, "R11 fill after race");
      step(0, 2'b11, 1, 3'd5, 0, 0, "R9 read-own on EXL");
      step(0, 2'b11, 1, 3'd6, 0, 0, "R12 snoop code 6");
      // R8 install from invalid
      step(0, 2'b11, 1, 3'd2, 0, 0, "R6 invalidate SHN");
      step(0, 2'b11, 1, 3'd4, 0, 0, "R8 no-other-copies");
      // R11 snooped read with write on exclusive
      step(1, 2'b01, 1, 3'd0, 0, 0, "R11 read with write");
      // R2 page fault fill
      step(0, 2'b11, 1, 3'd2, 0, 0, "R6 invalidate EXL");
      step(1, 2'b00, 0, 3'd6, 0, 0, "R2 read miss page");
      step(0, 2'b11, 0, 3'd6, 1, 1, "R2 page fill excl");
      step(0, 2'b11, 1, 3'd1, 0, 0, "R5 snoop write on EXL");
      idle();
      repeat (4) @(posedge clk);
      wait (q.size() == 0);
      repeat (2) @(posedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule